// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss. A requester hands it a 32-bit virtual address and the page directory base for the address space in use. The walker reads a directory entry from memory, then a table entry, and answers with a physical frame number, the access permissions and a non-secure flag. If the walk cannot finish, it answers with a fault and the level at which the walk stopped.

The walker handles one miss at a time. The requester side uses a valid/ready handshake. `req_ready_o` stays low from the cycle a request is accepted until the cycle after the response, so no second request can be accepted during a walk. Memory is reached through a read port with a valid/ready request and a valid response. There is never more than one read outstanding on that port.

The directory base input uses the same layout as an entry. Its low bits hold the directory address shifted right by 12. Bit 31 means readable, bit 30 writable and bit 29 non-secure. Translation caching and the storage of per-address-space bases are handled elsewhere.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready_o` is high only while the walker is idle. After a request is accepted it stays low until the cycle after the response pulse.
- R2: The first memory read goes to address `{base_frame, va[31:22], 2'b00}`. Here `base_frame` is `req_base_i` masked to its low `PA_W-12` bits.
- R3: If the directory entry is zero, or bit 28 (next-level flag) is clear, the walker answers with a fault at level 0 (`rsp_level_o`=0) and issues no second read. A fault response has pfn, read, write and non-secure all zero.
- R4: The second read goes to address `{pde_frame, va[21:12], 2'b00}`. Here `pde_frame` is the directory entry masked to its low `PA_W-12` bits. Entry bits between the frame field and bit 28 are ignored.
- R5: A table entry that is all zero gives a fault at level 1 (`rsp_level_o`=1).
- R6: On success `rsp_fault_o`=0 and `rsp_level_o`=0. `rsp_pfn_o` is the table entry masked to its low `PA_W-12` bits, and `rsp_nonsec_o` is table entry bit 29.
- R7: On success `rsp_read_o` is the AND of bit 31 of the base, the directory entry and the table entry. `rsp_write_o` is the same AND of bit 30.
- R8: `rsp_valid_o` is a one-cycle pulse, given exactly once for each accepted request.
- R9: `mem_req_valid_o` stays high with a stable address until `mem_req_ready_i` is sampled high. No new read is issued while a read response is still pending, and no read is issued while the walker is idle.
- R10: In the cycle after reset, `req_ready_o` is high and both `mem_req_valid_o` and `rsp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Miss request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_va_i | input | 32 | Virtual address to translate |
| req_base_i | input | 32 | Directory base: attribute bits 31:29, directory address >> 12 in the low bits |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| rsp_valid_o | output | 1 | Translation response pulse |
| rsp_fault_o | output | 1 | Walk failed |
| rsp_level_o | output | 1 | Fault level: 0 directory, 1 table |
| rsp_pfn_o | output | PA_W-12 | Physical frame number |
| rsp_read_o | output | 1 | Combined read permission |
| rsp_write_o | output | 1 | Combined write permission |
| rsp_nonsec_o | output | 1 | Non-secure flag of the table entry |

## Verification
The bench uses the default `PA_W` of 34, which gives a 22-bit frame field. Entry bits 27:22 then sit between the frame and the flags. The bench fills them, and the upper bits of the base, with junk to check that the masks in R2, R4 and R6 hold. Random latencies and stalls on the memory port check the holding rule of R9. The stimulus covers the extreme indexes 0 and 1023, entries that are non-zero but lack the next flag, and all combinations of permission bits across the three levels.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENTRY_W    = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int IDX_W      = 10;
  localparam int BIT_RD     = 31;
  localparam int BIT_WR     = 30;
  localparam int BIT_NS     = 29;
  localparam int BIT_NEXT   = 28;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT,
    ST_RESP
  } walk_state_e;
endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
#(
  parameter int PA_W = 34
) (
  input  logic [ENTRY_W-1:0]       entry_i,
  output logic [PA_W-PAGE_SHIFT-1:0] frame_o,
  output logic                     rd_o,
  output logic                     wr_o,
  output logic                     ns_o,
  output logic                     next_o,
  output logic                     empty_o
);
  localparam int FRAME_W = PA_W - PAGE_SHIFT;

  generate
    if (FRAME_W > BIT_NEXT) begin : g_bad
      initial $error("frame field overlaps entry flags");
      assign frame_o = entry_i[FRAME_W-1:0];
    end else begin : g_frame
      assign frame_o = entry_i[FRAME_W-1:0];
    end
  endgenerate

  assign rd_o    = entry_i[BIT_RD];
  assign wr_o    = entry_i[BIT_WR];
  assign ns_o    = entry_i[BIT_NS];
  assign next_o  = entry_i[BIT_NEXT];
  assign empty_o = (entry_i == '0);
endmodule

// File: rtl/ptw_fetch_addr.sv
module ptw_fetch_addr
  import ptw_pkg::*;
#(
  parameter int PA_W = 34
) (
  input  logic [PA_W-PAGE_SHIFT-1:0] frame_i,
  input  logic [IDX_W-1:0]           idx_i,
  output logic [PA_W-1:0]            addr_o
);
  // Page-aligned base plus index times four: the low 12 bits of the base are zero.
  assign addr_o = {frame_i, idx_i, 2'b00};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W    = 34,
  localparam int FRAME_W = PA_W - PAGE_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [31:0]        req_va_i,
  input  logic [31:0]        req_base_i,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [PA_W-1:0]    mem_req_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [31:0]        mem_rsp_data_i,
  output logic               rsp_valid_o,
  output logic               rsp_fault_o,
  output logic               rsp_level_o,
  output logic [FRAME_W-1:0] rsp_pfn_o,
  output logic               rsp_read_o,
  output logic               rsp_write_o,
  output logic               rsp_nonsec_o
);
  walk_state_e        state_q;
  logic [IDX_W-1:0]   tbl_idx_q;
  logic [PA_W-1:0]    addr_q;
  logic               rd_acc_q, wr_acc_q;
  logic               rsp_valid_q, rsp_fault_q, rsp_level_q;
  logic [FRAME_W-1:0] rsp_pfn_q;
  logic               rsp_rd_q, rsp_wr_q, rsp_ns_q;

  logic [FRAME_W-1:0] base_frame, ent_frame;
  logic               base_rd, base_wr, base_ns, base_next, base_empty;
  logic               ent_rd, ent_wr, ent_ns, ent_next, ent_empty;
  logic [PA_W-1:0]    dir_addr, tbl_addr;

  ptw_entry_decode #(.PA_W(PA_W)) u_base_dec (
    .entry_i (req_base_i),
    .frame_o (base_frame),
    .rd_o    (base_rd),
    .wr_o    (base_wr),
    .ns_o    (base_ns),
    .next_o  (base_next),
    .empty_o (base_empty)
  );

  ptw_entry_decode #(.PA_W(PA_W)) u_ent_dec (
    .entry_i (mem_rsp_data_i),
    .frame_o (ent_frame),
    .rd_o    (ent_rd),
    .wr_o    (ent_wr),
    .ns_o    (ent_ns),
    .next_o  (ent_next),
    .empty_o (ent_empty)
  );

  ptw_fetch_addr #(.PA_W(PA_W)) u_dir_addr (
    .frame_i (base_frame),
    .idx_i   (req_va_i[31:22]),
    .addr_o  (dir_addr)
  );

  ptw_fetch_addr #(.PA_W(PA_W)) u_tbl_addr (
    .frame_i (ent_frame),
    .idx_i   (tbl_idx_q),
    .addr_o  (tbl_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      tbl_idx_q   <= '0;
      addr_q      <= '0;
      rd_acc_q    <= 1'b0;
      wr_acc_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_level_q <= 1'b0;
      rsp_pfn_q   <= '0;
      rsp_rd_q    <= 1'b0;
      rsp_wr_q    <= 1'b0;
      rsp_ns_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            tbl_idx_q <= req_va_i[21:12];
            addr_q    <= dir_addr;
            rd_acc_q  <= base_rd;
            wr_acc_q  <= base_wr;
            state_q   <= ST_DIR_REQ;
          end
        end
        ST_DIR_REQ: begin
          if (mem_req_ready_i) state_q <= ST_DIR_WAIT;
        end
        ST_DIR_WAIT: begin
          if (mem_rsp_valid_i) begin
            if (ent_empty || !ent_next) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_level_q <= 1'b0;
              rsp_pfn_q   <= '0;
              rsp_rd_q    <= 1'b0;
              rsp_wr_q    <= 1'b0;
              rsp_ns_q    <= 1'b0;
              state_q     <= ST_RESP;
            end else begin
              addr_q   <= tbl_addr;
              rd_acc_q <= rd_acc_q & ent_rd;
              wr_acc_q <= wr_acc_q & ent_wr;
              state_q  <= ST_TBL_REQ;
            end
          end
        end
        ST_TBL_REQ: begin
          if (mem_req_ready_i) state_q <= ST_TBL_WAIT;
        end
        ST_TBL_WAIT: begin
          if (mem_rsp_valid_i) begin
            rsp_valid_q <= 1'b1;
            state_q     <= ST_RESP;
            if (ent_empty) begin
              rsp_fault_q <= 1'b1;
              rsp_level_q <= 1'b1;
              rsp_pfn_q   <= '0;
              rsp_rd_q    <= 1'b0;
              rsp_wr_q    <= 1'b0;
              rsp_ns_q    <= 1'b0;
            end else begin
              rsp_fault_q <= 1'b0;
              rsp_level_q <= 1'b0;
              rsp_pfn_q   <= ent_frame;
              rsp_rd_q    <= rd_acc_q & ent_rd;
              rsp_wr_q    <= wr_acc_q & ent_wr;
              rsp_ns_q    <= ent_ns;
            end
          end
        end
        ST_RESP: begin
          rsp_valid_q <= 1'b0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
  assign mem_req_addr_o  = addr_q;
  assign rsp_valid_o     = rsp_valid_q;
  assign rsp_fault_o     = rsp_fault_q;
  assign rsp_level_o     = rsp_level_q;
  assign rsp_pfn_o       = rsp_pfn_q;
  assign rsp_read_o      = rsp_rd_q;
  assign rsp_write_o     = rsp_wr_q;
  assign rsp_nonsec_o    = rsp_ns_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W = 34,
  localparam int FRAME_W = PA_W - 12
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               mem_req_valid_o,
  input logic               mem_req_ready_i,
  input logic [PA_W-1:0]    mem_req_addr_o,
  input logic               rsp_valid_o,
  input logic               rsp_fault_o,
  input logic [FRAME_W-1:0] rsp_pfn_o,
  input logic               rsp_read_o,
  input logic               rsp_write_o,
  input logic               rsp_nonsec_o
);
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_rsp_not_ready_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> !req_ready_o);

  assert_fault_clean_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && rsp_fault_o) |->
      (rsp_pfn_o == '0 && !rsp_read_o && !rsp_write_o && !rsp_nonsec_o));

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    req_ready_o |-> !mem_req_valid_o);

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready_o && !mem_req_valid_o && !rsp_valid_o));
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_fault_o     (rsp_fault_o),
  .rsp_pfn_o       (rsp_pfn_o),
  .rsp_read_o      (rsp_read_o),
  .rsp_write_o     (rsp_write_o),
  .rsp_nonsec_o    (rsp_nonsec_o)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 34;
  localparam int FW   = PA_W - 12;
  localparam logic [31:0] FMASK = (32'd1 << FW) - 32'd1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid_i = 1'b0;
  logic req_ready_o;
  logic [31:0] req_va_i = '0;
  logic [31:0] req_base_i = '0;
  logic mem_req_valid_o;
  logic mem_req_ready_i = 1'b0;
  logic [PA_W-1:0] mem_req_addr_o;
  logic mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic rsp_valid_o, rsp_fault_o, rsp_level_o;
  logic [FW-1:0] rsp_pfn_o;
  logic rsp_read_o, rsp_write_o, rsp_nonsec_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mem [logic [PA_W-1:0]];
  logic [PA_W-1:0] seen_addr [2];
  int n_reads;
  int pend;
  logic [31:0] pend_data;
  int proto_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker #(.PA_W(PA_W)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_va_i(req_va_i), .req_base_i(req_base_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o), .rsp_level_o(rsp_level_o),
    .rsp_pfn_o(rsp_pfn_o), .rsp_read_o(rsp_read_o), .rsp_write_o(rsp_write_o),
    .rsp_nonsec_o(rsp_nonsec_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_mem(input logic [PA_W-1:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'd0;
  endfunction

  function automatic logic [PA_W-1:0] ent_addr(input logic [31:0] ent, input logic [9:0] idx);
    logic [PA_W-1:0] a;
    a = PA_W'(ent & FMASK) << 12;
    return a + PA_W'(idx) * 4;
  endfunction

  // Memory model: random stalls and latency, records every accepted read.
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = pend_data;
        end
      end
      mem_req_ready_i = ($urandom % 3) != 0;
      if (mem_req_valid_o) begin
        if (pend > 0 || mem_rsp_valid_i) proto_err++;
        if (mem_req_ready_i) begin
          if (n_reads < 2) seen_addr[n_reads] = mem_req_addr_o;
          n_reads++;
          pend_data = rd_mem(mem_req_addr_o);
          pend = 1 + int'($urandom % 3);
        end
      end
      if (!rst && req_ready_o && mem_req_valid_o) proto_err++;
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base);
    logic [PA_W-1:0] a1, a2;
    logic [31:0] pde, pte;
    bit e_fault, e_lvl, e_rd, e_wr, e_ns;
    logic [FW-1:0] e_pfn;
    int e_reads, cyc, pulses, busy_ready;
    a1 = ent_addr(base, va[31:22]);
    pde = rd_mem(a1);
    a2 = '0; pte = '0;
    e_pfn = '0; e_rd = 0; e_wr = 0; e_ns = 0; e_lvl = 0;
    if (pde == 0 || !pde[28]) begin
      e_fault = 1; e_reads = 1;
    end else begin
      a2 = ent_addr(pde, va[21:12]);
      pte = rd_mem(a2);
      e_reads = 2;
      if (pte == 0) begin
        e_fault = 1; e_lvl = 1;
      end else begin
        e_fault = 0;
        e_pfn = FW'(pte & FMASK);
        e_rd = base[31] & pde[31] & pte[31];
        e_wr = base[30] & pde[30] & pte[30];
        e_ns = pte[29];
      end
    end
    n_reads = 0; proto_err = 0;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R1 idle ready", req_ready_o, 1);
    req_valid_i = 1'b1; req_va_i = va; req_base_i = base;
    @(negedge clk);
    req_valid_i = 1'b0; req_va_i = $urandom; req_base_i = $urandom;
    cyc = 0; pulses = 0; busy_ready = 0;
    while (!rsp_valid_o && cyc < 100) begin
      if (req_ready_o) busy_ready++;
      @(negedge clk);
      cyc++;
    end
    chk(busy_ready == 0, "R1 ready low during walk", busy_ready, 0);
    chk(rsp_valid_o == 1'b1, "R8 response seen", rsp_valid_o, 1);
    chk(n_reads == e_reads, "R3 read count", n_reads, e_reads);
    chk(seen_addr[0] == a1, "R2 directory address", seen_addr[0], a1);
    if (e_reads == 2) chk(seen_addr[1] == a2, "R4 table address", seen_addr[1], a2);
    chk(rsp_fault_o == e_fault, e_lvl ? "R5 fault flag" : "R3 fault flag", rsp_fault_o, e_fault);
    chk(rsp_level_o == e_lvl, "R5 fault level", rsp_level_o, e_lvl);
    chk(rsp_pfn_o == e_pfn, "R6 frame", rsp_pfn_o, e_pfn);
    chk(rsp_nonsec_o == e_ns, "R6 nonsecure", rsp_nonsec_o, e_ns);
    chk(rsp_read_o == e_rd, "R7 read perm", rsp_read_o, e_rd);
    chk(rsp_write_o == e_wr, "R7 write perm", rsp_write_o, e_wr);
    @(negedge clk);
    if (rsp_valid_o) pulses++;
    chk(pulses == 0, "R8 single pulse", pulses, 0);
    chk(proto_err == 0, "R9 memory protocol", proto_err, 0);
  endtask

  task automatic setup(input logic [31:0] va, input logic [31:0] base,
                       input logic [31:0] pde, input logic [31:0] pte);
    mem.delete();
    mem[ent_addr(base, va[31:22])] = pde;
    if (pde != 0 && pde[28]) mem[ent_addr(pde, va[21:12])] = pte;
    walk(va, base);
  endtask

  function automatic logic [31:0] rnd_entry(input bit nxt);
    logic [31:0] e;
    e = $urandom;
    e[28] = nxt;
    return e;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    n_reads = 0; pend = 0; proto_err = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R10 ready after reset", req_ready_o, 1);
    chk(mem_req_valid_o == 1'b0, "R10 no read after reset", mem_req_valid_o, 0);
    chk(rsp_valid_o == 1'b0, "R10 no response after reset", rsp_valid_o, 0);
    // Directed: full permissions, extreme indexes, junk above frame field (R2 R4 R6).
    setup(32'hFFFF_F000, 32'hEFC0_0123, 32'hF0FC_0456, 32'hFFFF_FFFF);
    setup(32'h0000_0000, 32'hE000_0001, 32'hF000_0002, 32'hE000_0003);
    // Directory entry non-zero without next flag (R3), zero directory entry (R3).
    setup(32'h1234_5000, 32'hE000_0010, 32'hE000_0777, 32'h0);
    setup(32'h8765_4000, 32'hE000_0010, 32'h0, 32'h0);
    // Zero table entry (R5); entry with only nonsecure flag (R6 R7).
    setup(32'h4000_1000, 32'hE000_0020, 32'hD000_0100, 32'h0);
    setup(32'h4000_2000, 32'h2000_0020, 32'h9000_0100, 32'h2000_0000);
    for (int i = 0; i < 200; i++) begin
      int k;
      logic [31:0] pde;
      k = int'($urandom % 10);
      pde = (k == 0) ? 32'h0 : rnd_entry(k != 1);
      setup($urandom, $urandom, pde, ((k == 2) ? 32'h0 : 32'($urandom)));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule